// File: doc/BRIEF.md
# Branch Fetch Steering Controller

This block decides which address the fetch stage of a five-stage pipeline uses next, and which instructions fetched after a conditional branch must be discarded. A branch is resolved somewhere downstream, and that stage presents the branch address, its offset and its outcome. By the time the outcome is known, a fixed number of younger instructions (`DEPTH`, three by default) have already been fetched behind the branch. Without speculation, each branch would cost that many stall cycles.

Two policies can be selected. Under predict-not-taken, fetch keeps running sequentially past every branch. A taken branch discards all younger instructions and moves fetch to the target. Under the delay-slot policy, the first instruction after the branch always completes. The exception is a canceling branch, which is expected to be taken: if it falls through, its slot instruction is discarded. The squash mask and the redirect are produced in the same cycle that the outcome arrives.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc_o` loads `RESET_PC`. With no branch resolving, `kill_o` is zero and `redirect_o` is low.
- R2: With no redirect and `stall_i` low, `pc_o` advances by 4 each cycle, modulo 2^AW.
- R3: With `stall_i` high and no redirect, `pc_o` holds its value and `fetch_hold_o` is high.
- R4: When `br_resolve_i` and `br_taken_i` are both high, `redirect_o` is high in that same cycle. In that cycle `next_pc_o` equals `br_pc_i + 4 + br_offset_i` (modulo 2^AW), and `pc_o` takes this value at the next edge. For example, a branch at 40 with offset 36 goes to 80. The offset is a two's-complement multiple of 4.
- R5: When `policy_i` is 0 (predict-not-taken) and the resolving branch is not taken, `kill_o` is zero, `redirect_o` is low and fetch continues by +4 with no cycle lost.
- R6: When `policy_i` is 0 and the branch is taken, every bit of `kill_o` is set. Bit i of `kill_o` marks the (i+1)-th instruction fetched after the branch.
- R7: When `policy_i` is 1 (delay slot) and the branch is taken, `kill_o[0]` (the slot) is clear and all higher bits are set, whether or not the branch is canceling.
- R8: When `policy_i` is 1 and a non-canceling branch (`br_cancel_i` low) is not taken, `kill_o` is zero.
- R9: When `policy_i` is 1 and a canceling branch (`br_cancel_i` high) is not taken, only `kill_o[0]` is set.
- R10: When `policy_i` is 0, `br_cancel_i` has no effect on `kill_o`, `redirect_o` or the PC.
- R11: A redirect takes priority over `stall_i`: the target is loaded and `fetch_hold_o` stays low.
- R12: `pc_o` stays 4-byte aligned (bits 1:0 zero) when `RESET_PC` is aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 1 | 0 = predict-not-taken, 1 = delay slot |
| stall_i | input | 1 | Request to hold fetch this cycle |
| br_resolve_i | input | 1 | A branch outcome is present this cycle |
| br_taken_i | input | 1 | Resolved direction, 1 = taken |
| br_cancel_i | input | 1 | Branch is canceling (slot kept only if taken) |
| br_pc_i | input | AW | Address of the resolving branch |
| br_offset_i | input | AW | Two's-complement byte offset |
| pc_o | output | AW | Current fetch address |
| next_pc_o | output | AW | Address loaded at the next edge |
| redirect_o | output | 1 | Fetch moves to the branch target |
| fetch_hold_o | output | 1 | Fetch stage is held this cycle |
| kill_o | output | DEPTH | Per-instruction squash mask for younger fetches |

## Verification
The bench builds the block with `AW` = 10 and `DEPTH` = 3. The 1 KB address space lets branches near the top of memory wrap their targets through zero, and lets the offsets cover forward, backward and zero distances. `DEPTH` = 3 gives a slot bit plus two younger bits, so the slot-only, all-but-slot and all-bits masks can each be told apart. The bench sweeps every combination of policy, canceling flag, outcome and stall across several branch addresses and offsets.

// File: rtl/bfc_pkg.sv
// Package: shared types for the branch fetch steering controller.
// Assumes a 4-byte instruction size throughout.
package bfc_pkg;
    typedef enum logic {
        POL_PREDICT_NT = 1'b0,
        POL_DELAY_SLOT = 1'b1
    } policy_e;

    localparam int INSTR_BYTES = 4;
endpackage

// File: rtl/bfc_target.sv
// Module: bfc_target
// Computes the branch target as branch address + instruction size + offset.
// Assumes the offset is two's complement in AW bits; the sum wraps modulo 2^AW.
module bfc_target #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] br_pc,
    input  logic [AW-1:0] br_offset,
    output logic [AW-1:0] target
);
    localparam logic [AW-1:0] STEP = AW'(bfc_pkg::INSTR_BYTES);

    // Target adder.
    always_comb begin
        target = br_pc + STEP + br_offset;
    end
endmodule

// File: rtl/bfc_squash.sv
// Module: bfc_squash
// Builds the squash mask for the DEPTH instructions fetched behind a
// resolving branch. Bit 0 is the slot directly after the branch.
// Assumes the younger instructions sit in age order in the pipe.
module bfc_squash #(
    parameter int DEPTH = 3
) (
    input  logic              resolve,
    input  logic              taken,
    input  logic              cancel,
    input  bfc_pkg::policy_e  policy,
    output logic [DEPTH-1:0]  kill
);
    import bfc_pkg::*;

    logic slot_mode;

    // Policy decode.
    always_comb begin
        slot_mode = (policy == POL_DELAY_SLOT);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        if (i == 0) begin : g_slot
            // Slot: dropped on a taken predict-not-taken branch or an untaken canceling one.
            always_comb begin
                kill[i] = resolve && (slot_mode ? (cancel && !taken) : taken);
            end
        end else begin : g_young
            // Deeper instructions: dropped on any taken branch.
            always_comb begin
                kill[i] = resolve && taken;
            end
        end
    end
endmodule

// File: rtl/bfc_pc_reg.sv
// Module: bfc_pc_reg
// Holds the fetch PC and chooses the next one: the redirect target first,
// then a hold on stall, else a sequential step.
// Assumes RESET_PC is aligned to the instruction size.
module bfc_pc_reg #(
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect,
    input  logic          hold,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] next_pc
);
    localparam logic [AW-1:0] STEP = AW'(bfc_pkg::INSTR_BYTES);

    // Next-address select.
    always_comb begin
        if (redirect)  next_pc = target;
        else if (hold) next_pc = pc;
        else           next_pc = pc + STEP;
    end

    // PC register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= next_pc;
    end
endmodule

// File: rtl/branch_fetch_ctrl.sv
// Module: branch_fetch_ctrl
// Steers fetch around conditional branches under either policy: predict-not-taken
// or a single delay slot with canceling support.
// Assumes an outcome arrives with exactly DEPTH younger instructions fetched.
module branch_fetch_ctrl #(
    parameter int             AW       = 32,
    parameter int             DEPTH    = 3,
    parameter logic [AW-1:0]  RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_i,
    input  logic             stall_i,
    input  logic             br_resolve_i,
    input  logic             br_taken_i,
    input  logic             br_cancel_i,
    input  logic [AW-1:0]    br_pc_i,
    input  logic [AW-1:0]    br_offset_i,
    output logic [AW-1:0]    pc_o,
    output logic [AW-1:0]    next_pc_o,
    output logic             redirect_o,
    output logic             fetch_hold_o,
    output logic [DEPTH-1:0] kill_o
);
    import bfc_pkg::*;

    logic [AW-1:0] target;
    policy_e       policy;

    // Redirect, hold and policy decode.
    always_comb begin
        policy       = policy_e'(policy_i);
        redirect_o   = br_resolve_i && br_taken_i;
        fetch_hold_o = stall_i && !redirect_o;
    end

    bfc_target #(.AW(AW)) u_target (
        .br_pc     (br_pc_i),
        .br_offset (br_offset_i),
        .target    (target)
    );

    bfc_squash #(.DEPTH(DEPTH)) u_squash (
        .resolve (br_resolve_i),
        .taken   (br_taken_i),
        .cancel  (br_cancel_i),
        .policy  (policy),
        .kill    (kill_o)
    );

    bfc_pc_reg #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect_o),
        .hold     (fetch_hold_o),
        .target   (target),
        .pc       (pc_o),
        .next_pc  (next_pc_o)
    );
endmodule

// File: rtl/bfc_checker.sv
// Module: bfc_checker
// Property checks for branch_fetch_ctrl, attached with bind below.
module bfc_checker #(
    parameter int AW    = 32,
    parameter int DEPTH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             policy_i,
    input logic             stall_i,
    input logic             br_resolve_i,
    input logic             br_taken_i,
    input logic             br_cancel_i,
    input logic [AW-1:0]    br_pc_i,
    input logic [AW-1:0]    br_offset_i,
    input logic [AW-1:0]    pc_o,
    input logic             redirect_o,
    input logic             fetch_hold_o,
    input logic [DEPTH-1:0] kill_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !br_resolve_i |-> (kill_o == '0) && !redirect_o);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_resolve_i && !stall_i) |=> pc_o == AW'($past(pc_o) + STEP));

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !br_resolve_i) |=> $stable(pc_o));

    assert_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve_i && br_taken_i) |=>
            pc_o == AW'($past(br_pc_i) + STEP + $past(br_offset_i)));

    assert_pnt_fallthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve_i && !br_taken_i && !policy_i) |-> (kill_o == '0) && !redirect_o);

    assert_pnt_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve_i && br_taken_i && !policy_i) |-> $countones(kill_o) == DEPTH);

    assert_slot_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve_i && br_taken_i && policy_i) |->
            !kill_o[0] && ($countones(kill_o) == DEPTH - 1));

    assert_slot_nt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve_i && !br_taken_i && policy_i && !br_cancel_i) |-> kill_o == '0);

    assert_cancel_nt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_resolve_i && !br_taken_i && policy_i && br_cancel_i) |->
            kill_o[0] && ($countones(kill_o) == 1));

    assert_hold_yield_R11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !fetch_hold_o);

    assert_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);
endmodule

bind branch_fetch_ctrl bfc_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy_i     (policy_i),
    .stall_i      (stall_i),
    .br_resolve_i (br_resolve_i),
    .br_taken_i   (br_taken_i),
    .br_cancel_i  (br_cancel_i),
    .br_pc_i      (br_pc_i),
    .br_offset_i  (br_offset_i),
    .pc_o         (pc_o),
    .redirect_o   (redirect_o),
    .fetch_hold_o (fetch_hold_o),
    .kill_o       (kill_o)
);

// File: tb/sim_branch_fetch_ctrl.sv
// Bench: sweeps policy, cancel, outcome, stall, branch address and offset
// on a 10-bit, depth-3 build; expected values are computed arithmetically.
module sim_branch_fetch_ctrl;
    localparam int            AW         = 10;
    localparam int            DEPTH      = 3;
    localparam logic [AW-1:0] RST_PC     = AW'(256);
    localparam int            CLK_PERIOD = 10;
    localparam int            FULL       = (1 << DEPTH) - 1;
    localparam int            OFFS [6]   = '{0, 4, -4, 36, -40, 508};
    localparam int            PCS  [4]   = '{40, 0, 1020, 512};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             policy_i = 1'b0, stall_i = 1'b0;
    logic             br_resolve_i = 1'b0, br_taken_i = 1'b0, br_cancel_i = 1'b0;
    logic [AW-1:0]    br_pc_i = '0, br_offset_i = '0;
    logic [AW-1:0]    pc_o, next_pc_o;
    logic             redirect_o, fetch_hold_o;
    logic [DEPTH-1:0] kill_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [AW-1:0] exp_pc;

    branch_fetch_ctrl #(.AW(AW), .DEPTH(DEPTH), .RESET_PC(RST_PC)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: counts as a failed check and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 50000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", int'(pc_o), int'(RST_PC));
        chk("R1 kill", int'(kill_o), 0);
        chk("R1 redirect", int'(redirect_o), 0);
        rst_n = 1'b1;
        exp_pc = RST_PC;

        // R2 / R12: sequential stepping
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            exp_pc = AW'(exp_pc + AW'(4));
            chk("R2 step", int'(pc_o), int'(exp_pc));
            chk("R12 align", int'(pc_o[1:0]), 0);
        end

        // R3: stall holds fetch
        stall_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R3 hold flag", int'(fetch_hold_o), 1);
            @(negedge clk);
            chk("R3 pc held", int'(pc_o), int'(exp_pc));
        end
        stall_i = 1'b0;

        // R4: branch at 40 with offset 36 goes to 80
        policy_i = 1'b0; br_resolve_i = 1'b1; br_taken_i = 1'b1;
        br_pc_i = AW'(40); br_offset_i = AW'(36);
        #1;
        chk("R4 next_pc example", int'(next_pc_o), 80);
        @(negedge clk);
        chk("R4 pc example", int'(pc_o), 80);
        exp_pc = AW'(80);
        br_resolve_i = 1'b0;

        // Sweep: policy x cancel x taken x stall x branch pc x offset
        for (int pol = 0; pol < 2; pol++)
        for (int can = 0; can < 2; can++)
        for (int tk = 0; tk < 2; tk++)
        for (int st = 0; st < 2; st++)
        for (int pi = 0; pi < 4; pi++)
        for (int oi = 0; oi < 6; oi++) begin
            int    ek;
            int    tgt;
            string tag;
            logic [AW-1:0] enext;
            policy_i = pol[0]; br_cancel_i = can[0]; br_taken_i = tk[0];
            stall_i = st[0]; br_resolve_i = 1'b1;
            br_pc_i = AW'(PCS[pi]); br_offset_i = AW'(OFFS[oi]);
            tgt = (PCS[pi] + 4 + OFFS[oi]) & ((1 << AW) - 1);
            if (pol == 0) begin
                ek  = tk ? FULL : 0;
                tag = can ? "R10" : (tk ? "R6" : "R5");
            end else begin
                ek  = tk ? (FULL & ~1) : (can ? 1 : 0);
                tag = tk ? "R7" : (can ? "R9" : "R8");
            end
            if (tk != 0)      enext = AW'(tgt);
            else if (st != 0) enext = exp_pc;
            else              enext = AW'(exp_pc + AW'(4));
            #1;
            chk({tag, " kill"}, int'(kill_o), ek);
            chk({tag, " redirect"}, int'(redirect_o), tk);
            chk(tk ? "R4 next_pc" : (st ? "R3 next_pc" : {tag, " next_pc"}),
                int'(next_pc_o), int'(enext));
            chk((st && tk) ? "R11 hold" : "R3 hold", int'(fetch_hold_o),
                (st != 0 && tk == 0) ? 1 : 0);
            @(negedge clk);
            exp_pc = enext;
            chk(tk ? ((st != 0) ? "R11 pc" : "R4 pc") : {tag, " pc"},
                int'(pc_o), int'(exp_pc));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule